// File: doc/BRIEF.md
# Configurable Multi-Width SPI Slave

This block is the target side of a full-duplex SPI link. An external master drives the serial clock, the data line toward the block and a select line. The block answers on its own data line in the same serial clock cycles. The serial clock, the incoming data and the select line are sampled by the system clock through short synchroniser chains. Serial clock edges are found by comparing one synchronised sample with the next, so no logic in the block runs on the serial clock itself.

Four settings can change at run time: the frame length (1 to 128 bits), the clock phase, the idle level of the serial clock and the active level of the select line. They may be changed only while the enable input is low. When a frame opens, the block copies a preset transmit word and shifts it out most significant bit first. When the configured number of bits has been sampled, the block presents the received word, right-aligned, together with a one-cycle valid pulse.

Top module: `spi_slave_cfg`

## Requirements
- R1: A frame holds cfg_len_m1 + 1 bits, so values 0 to 127 give lengths of 1 to 128 bits. rx_valid rises only after exactly that many bits have been sampled.
- R2: Both directions run most significant bit first. rx_word holds the received bits right-aligned, and every bit above the frame length is 0.
- R3: With cfg_cpha = 0, the most significant transmit bit is on miso_out before the first serial clock edge. The block samples on each leading edge and moves miso_out on each trailing edge.
- R4: With cfg_cpha = 1, miso_out keeps the most significant bit through the first leading edge and moves on every later leading edge. The block samples on each trailing edge.
- R5: cfg_cpol gives the idle level of the serial clock (0 = low, 1 = high). The leading edge is the edge that leaves the idle level.
- R6: The select line is active when sel_in equals cfg_sel_pol (1 = active high, 0 = active low). A frame opens when select becomes active while enable is high, and the transmit word is loaded at that point.
- R7: rx_valid is a single-cycle pulse. rx_word changes only in the cycle where rx_valid is high and holds its value at all other times.
- R8: If select goes inactive before the frame is complete, no rx_valid pulse is produced and the bit counter restarts. The next frame is then received correctly.
- R9: miso_out is 0 whenever no frame is open, including while select is inactive or enable is low.
- R10: While enable is low, serial clock and select activity open no frame and produce no rx_valid pulse.
- R11: After reset, rx_word is 0, rx_valid is 0 and miso_out is 0.
- R12: Once a frame is complete, further serial clock edges are ignored until select goes inactive and active again. They produce no second pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; settings may change only while this is low |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on the leading edge, 1 = sample on the trailing edge |
| cfg_sel_pol | input | 1 | Active level of sel_in |
| cfg_len_m1 | input | 7 | Frame length minus one |
| tx_word | input | 128 | Word sent in the next frame, right-aligned |
| sck_in | input | 1 | Serial clock from the master |
| mosi_in | input | 1 | Serial data from the master |
| sel_in | input | 1 | Select line from the master |
| miso_out | output | 1 | Serial data to the master |
| rx_word | output | 128 | Last complete received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |

## Verification
The bench acts as the master and runs all four clock modes at different frame lengths. It also covers the extreme lengths of 1 and 128 bits, where an off-by-one in the counter or the alignment shift would either drop the valid pulse or move data into the wrong bits. It aborts a frame partway through and then checks that the following frame arrives intact; a counter that is not cleared on abort would end that next frame early and shift the received word. It also sends extra clocks after a completed frame, runs a frame with enable low, and checks that miso_out stays at 0 with an all-ones transmit word while no frame is open. A design that behaves wrongly in these cases would emit a second pulse, accept the disabled frame, or leak the transmit MSB onto the line.

// File: rtl/spis_pkg.sv
package spis_pkg;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic sel_pol;
  } spis_mode_t;

  // Edge leaving the idle level of the serial clock.
  function automatic logic lead_edge(input logic cpol, input logic rise, input logic fall);
    return cpol ? fall : rise;
  endfunction

  // Edge returning to the idle level.
  function automatic logic trail_edge(input logic cpol, input logic rise, input logic fall);
    return cpol ? rise : fall;
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spis_edge.sv
module spis_edge
  import spis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  spis_mode_t mode,
  input  logic       sck_s,
  input  logic       sel_s,
  output logic       sel_act,
  output logic       frame_start,
  output logic       lead_ev,
  output logic       trail_ev
);

  logic sck_q;
  logic act_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      act_q <= sel_act;
    end
  end

  assign sel_act     = enable & (sel_s == mode.sel_pol);
  assign frame_start = sel_act & ~act_q;
  assign rise        = sck_s & ~sck_q;
  assign fall        = ~sck_s & sck_q;
  assign lead_ev     = sel_act & lead_edge(mode.cpol, rise, fall);
  assign trail_ev    = sel_act & trail_edge(mode.cpol, rise, fall);

endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic [CNT_W-1:0]  len_m1,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sel_act,
  input  logic              frame_start,
  input  logic              lead_ev,
  input  logic              trail_ev,
  input  logic              mosi_s,
  output logic              miso,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              sample_ev,
  output logic              shift_ev,
  output logic              in_frame,
  output logic [CNT_W-1:0]  bit_cnt
);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] rx_next;
  logic              done;
  logic              last_bit;

  // Put bit len_m1 of the word at the top of the shifter.
  function automatic logic [DATA_W-1:0] align_tx(input logic [DATA_W-1:0] w,
                                                 input logic [CNT_W-1:0] l);
    return w << (DATA_W - 1 - int'(l));
  endfunction

  function automatic logic [DATA_W-1:0] push_bit(input logic [DATA_W-1:0] w, input logic b);
    return (w << 1) | DATA_W'(b);
  endfunction

  assign sample_ev = in_frame & ~done & (cpha ? trail_ev : lead_ev);
  assign shift_ev  = in_frame & ~done & (cpha ? (lead_ev & (bit_cnt != '0)) : trail_ev);
  assign last_bit  = sample_ev & (bit_cnt == len_m1);
  assign rx_next   = push_bit(rx_sh, mosi_s);
  assign miso      = in_frame & tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      in_frame <= 1'b0;
      done     <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (frame_start) begin
        in_frame <= 1'b1;
        tx_sh    <= align_tx(tx_word, len_m1);
        rx_sh    <= '0;
        bit_cnt  <= '0;
        done     <= 1'b0;
      end else if (!sel_act) begin
        in_frame <= 1'b0;
        bit_cnt  <= '0;
        done     <= 1'b0;
      end else begin
        if (shift_ev) tx_sh <= tx_sh << 1;
        if (sample_ev) begin
          rx_sh <= rx_next;
          if (last_bit) begin
            done     <= 1'b1;
            bit_cnt  <= '0;
            rx_word  <= rx_next;
            rx_valid <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_slave_cfg.sv
module spi_slave_cfg
  import spis_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_sel_pol,
  input  logic [CNT_W-1:0]  cfg_len_m1,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sck_in,
  input  logic              mosi_in,
  input  logic              sel_in,
  output logic              miso_out,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);

  spis_mode_t mode;
  logic [2:0] pins_s;
  logic       sel_act;
  logic       frame_start;
  logic       lead_ev;
  logic       trail_ev;
  logic       sample_ev;
  logic       shift_ev;
  logic       in_frame;
  logic [CNT_W-1:0] bit_cnt;

  assign mode = '{cpha: cfg_cpha, cpol: cfg_cpol, sel_pol: cfg_sel_pol};

  spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck_in, mosi_in, sel_in}),
    .q     (pins_s)
  );

  spis_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .mode        (mode),
    .sck_s       (pins_s[2]),
    .sel_s       (pins_s[0]),
    .sel_act     (sel_act),
    .frame_start (frame_start),
    .lead_ev     (lead_ev),
    .trail_ev    (trail_ev)
  );

  spis_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpha        (cfg_cpha),
    .len_m1      (cfg_len_m1),
    .tx_word     (tx_word),
    .sel_act     (sel_act),
    .frame_start (frame_start),
    .lead_ev     (lead_ev),
    .trail_ev    (trail_ev),
    .mosi_s      (pins_s[1]),
    .miso        (miso_out),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid),
    .sample_ev   (sample_ev),
    .shift_ev    (shift_ev),
    .in_frame    (in_frame),
    .bit_cnt     (bit_cnt)
  );

endmodule

// File: rtl/spis_check.sv
module spis_check #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              miso_out,
  input logic [DATA_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              sample_ev,
  input logic              frame_start,
  input logic              in_frame,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CNT_W-1:0]  cfg_len_m1
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word)); // R7
  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sample_ev)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> (bit_cnt <= cfg_len_m1)); // R1
  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_cnt == '0)); // R8
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $past(!enable)) |-> !miso_out); // R9
  AST_NO_VALID_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(enable)); // R10

endmodule

bind spi_slave_cfg spis_check #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_spis_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .miso_out    (miso_out),
  .rx_word     (rx_word),
  .rx_valid    (rx_valid),
  .sample_ev   (sample_ev),
  .frame_start (frame_start),
  .in_frame    (in_frame),
  .bit_cnt     (bit_cnt),
  .cfg_len_m1  (cfg_len_m1)
);

// File: tb/test_spi_slave_cfg.sv
module test_spi_slave_cfg;

  localparam int CLK_P = 10;
  localparam int H     = 8;   // system cycles per serial half period

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         cfg_cpol = 1'b0;
  logic         cfg_cpha = 1'b0;
  logic         cfg_sel_pol = 1'b0;
  logic [6:0]   cfg_len_m1 = '0;
  logic [127:0] tx_word = '0;
  logic         sck_in = 1'b0;
  logic         mosi_in = 1'b0;
  logic         sel_in = 1'b1;
  logic         miso_out;
  logic [127:0] rx_word;
  logic         rx_valid;

  int checks = 0;
  int fails  = 0;
  int vcnt   = 0;
  logic [127:0] cap = '0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_slave_cfg i_spi_slave_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_sel_pol(cfg_sel_pol), .cfg_len_m1(cfg_len_m1),
    .tx_word(tx_word), .sck_in(sck_in), .mosi_in(mosi_in), .sel_in(sel_in),
    .miso_out(miso_out), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always @(negedge clk) if (rx_valid) begin vcnt++; cap = rx_word; end

  function automatic logic [127:0] low_mask(input int n);
    return (n >= 128) ? '1 : ((128'(1) << n) - 128'(1));
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Master side of one frame; select stays active on return.
  task automatic run_frame(input logic cpol, input logic cpha, input logic spol,
                           input logic en, input int n, input logic [127:0] mdata,
                           input logic [127:0] sdata, input int bits, input int extra,
                           output logic [127:0] got);
    enable = 1'b0;
    idle(2);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_sel_pol = spol;
    cfg_len_m1 = 7'(n - 1); tx_word = sdata;
    sck_in = cpol; sel_in = ~spol; mosi_in = 1'b0;
    idle(4);
    enable = en;
    idle(6);
    got = '0;
    sel_in = spol;
    for (int i = 0; i < bits + extra; i++) begin
      logic b;
      b = (i < n) ? mdata[n-1-i] : 1'b0;
      if (!cpha) begin
        mosi_in = b;
        idle(H);
        if (i < n) got[n-1-i] = miso_out;
        sck_in = ~cpol;
        idle(H);
        sck_in = cpol;
      end else begin
        idle(H);
        sck_in = ~cpol;
        mosi_in = b;
        idle(H);
        sck_in = cpol;
        if (i < n) got[n-1-i] = miso_out;
      end
    end
    idle(H);
  endtask

  task automatic end_frame(input string req);
    sel_in = ~cfg_sel_pol;
    idle(H);
    chk(req, 128'(miso_out), 128'(0));
  endtask

  task automatic full_case(input string tag, input logic cpol, input logic cpha,
                           input logic spol, input int n, input logic [127:0] md,
                           input logic [127:0] sd);
    logic [127:0] got;
    int v0;
    v0 = vcnt;
    run_frame(cpol, cpha, spol, 1'b1, n, md, sd, n, 0, got);
    chk({tag, " valid count R7"}, 128'(vcnt - v0), 128'(1));
    chk({tag, " rx_word R2"}, cap, md & low_mask(n));
    chk({tag, cpha ? " miso R4" : " miso R3"}, got, sd & low_mask(n));
    end_frame({tag, " idle R9"});
  endtask

  task automatic t_reset;
    chk("reset rx_valid R11", 128'(rx_valid), 128'(0));
    chk("reset miso R11", 128'(miso_out), 128'(0));
    chk("reset rx_word R11", rx_word, 128'(0));
  endtask

  task automatic t_modes;
    full_case("mode0 R5", 1'b0, 1'b0, 1'b0, 8,  128'hA5, 128'h3C);
    full_case("mode1 R5", 1'b0, 1'b1, 1'b0, 16, 128'h1234, 128'hBEEF);
    full_case("mode2 R5", 1'b1, 1'b0, 1'b0, 13, 128'h1ACE, 128'h0F0F);
    full_case("mode3 R5", 1'b1, 1'b1, 1'b0, 24, 128'hC0FFEE, 128'h5A5A5A);
  endtask

  task automatic t_widths;
    full_case("len1 cpha0 R1", 1'b0, 1'b0, 1'b0, 1, 128'h1, 128'h1);
    full_case("len1 cpha1 R1", 1'b1, 1'b1, 1'b0, 1, 128'h0, 128'h1);
    full_case("len128 R1", 1'b0, 1'b1, 1'b0, 128,
              128'h8123_4567_89AB_CDEF_0011_2233_4455_6677,
              128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F);
    full_case("len40 upper bits R2", 1'b0, 1'b0, 1'b0, 40, '1, 128'h80_0000_0001);
  endtask

  task automatic t_selpol;
    full_case("active-high select R6", 1'b0, 1'b0, 1'b1, 10, 128'h2D5, 128'h1B3);
  endtask

  task automatic t_extra;
    logic [127:0] got;
    int v0;
    v0 = vcnt;
    run_frame(1'b0, 1'b0, 1'b0, 1'b1, 8, 128'h6B, 128'h91, 8, 3, got);
    chk("extra clocks one pulse R12", 128'(vcnt - v0), 128'(1));
    chk("extra clocks rx_word R12", cap, 128'h6B);
    end_frame("extra clocks idle R9");
  endtask

  task automatic t_abort;
    logic [127:0] got;
    int v0;
    v0 = vcnt;
    run_frame(1'b0, 1'b1, 1'b0, 1'b1, 12, 128'hFFF, 128'hABC, 5, 0, got);
    end_frame("abort idle R9");
    chk("abort no pulse R8", 128'(vcnt - v0), 128'(0));
    full_case("after abort R8", 1'b0, 1'b1, 1'b0, 12, 128'h9C3, 128'h5E7);
  endtask

  task automatic t_idle_miso;
    enable = 1'b0;
    idle(2);
    tx_word = '1; cfg_len_m1 = 7'd127; cfg_sel_pol = 1'b0; sel_in = 1'b1;
    idle(2);
    enable = 1'b1;
    idle(10);
    chk("miso idle with select inactive R9", 128'(miso_out), 128'(0));
  endtask

  task automatic t_disabled;
    logic [127:0] got;
    int v0;
    v0 = vcnt;
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 8, 128'hFF, 128'hFF, 8, 0, got);
    chk("disabled no pulse R10", 128'(vcnt - v0), 128'(0));
    chk("disabled miso quiet R10", got, 128'(0));
    end_frame("disabled idle R9");
  endtask

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_modes;
    t_widths;
    t_selpol;
    t_extra;
    t_abort;
    t_idle_miso;
    t_disabled;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule